// File: doc/BRIEF.md
# Manchester Line Encoder and Decoder

This block turns a serial NRZ bit stream into Manchester line symbols on the transmit side. On the receive side it recovers the bit timing from a Manchester line input. It runs on a single oversampling clock, with OSR clock cycles per bit cell. The transmit side is paced by a free-running cell counter that starts at reset, so the data source drives its bits in step with that counter.

The receive side brings the line into the clock domain through two flip-flops. It hunts for a mid-cell transition and then locks onto the bit phase, restarting its phase count at every accepted transition. Edges near cell boundaries are ignored. Each accepted transition yields one NRZ bit, which is presented with a recovered clock pulse. Carrier sense follows the lock state. Whenever there is no carrier, the recovered clock stays low, so nothing toggles while the line is idle.

Top module: `manchester_endec`

## Requirements
- R1: While a cell is enabled, a 1 is sent as low for the first OSR/2 clocks of the cell and high for the last OSR/2 clocks; a 0 is sent as high and then low.
- R2: tx_en and tx_nrz are sampled at the OSR-th rising edge after reset release and at every OSR-th edge after that. The cell begins right after the sampling edge. A cell sampled with tx_en low holds tx_line low for the whole cell.
- R3: Each accepted mid-cell transition produces one bit on rx_nrz, equal to the line level after the transition (rising edge gives 1, falling edge gives 0). rx_clk rises in the same cycle as the new bit appears and stays high for OSR/2 clocks. rx_nrz holds its value until the next accepted transition. The line passes through two synchroniser stages first.
- R4: From idle, the first edge is taken as a candidate. rx_carrier rises only when a second edge is accepted after that candidate. A single isolated edge never raises carrier.
- R5: An edge arriving less than 3*OSR/4 clocks after the last accepted or candidate transition is ignored. This is how cell-boundary edges in runs of equal bits are dropped.
- R6: If no edge is accepted for 3*OSR/2 clocks, rx_carrier falls and the decoder returns to hunting.
- R7: rx_clk is low whenever rx_carrier is low.
- R8: Any line edge may be displaced by up to OSR/16 clocks. Because the phase count restarts at every accepted transition, such displacement does not accumulate, and a packet still decodes correctly.
- R9: During and after reset, tx_line, rx_clk, rx_nrz and rx_carrier are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OSR cycles per bit |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable for the next cell |
| tx_nrz | input | 1 | Transmit data bit for the next cell |
| tx_line | output | 1 | Manchester line output |
| rx_line | input | 1 | Manchester line input, asynchronous |
| rx_clk | output | 1 | Recovered bit clock |
| rx_nrz | output | 1 | Recovered data bit |
| rx_carrier | output | 1 | Carrier sense |

## Verification
The hardest case to reach from the ports is a long packet whose mid-cell transitions each drift by a different random amount. Boundary edges also move inside the same packet. A decoder that failed to resynchronise, or that set its window too wide, would then slip a bit or lock onto a boundary. The bench builds each received packet from half-cell boundaries, and every boundary gets its own random shift of up to OSR/16 clocks. Directed all-ones and all-zeros packets exercise the boundary-ignore window, and a lone edge held longer than the timeout checks that carrier is not raised falsely.

// File: rtl/manchester_pkg.sv
package manchester_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_CAND,
    S_LOCK
  } dec_state_t;

  // Line level for one sample of a cell: first half carries the inverse.
  function automatic logic cell_level(input logic en, input logic data,
                                      input logic second_half);
    return en & (second_half ? data : ~data);
  endfunction

endpackage

// File: rtl/manchester_enc.sv
module manchester_enc #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_nrz,
  output logic tx_line
);
  import manchester_pkg::*;

  localparam int HALF = OSR / 2;
  localparam int PW   = $clog2(OSR);

  logic [PW-1:0] ph;
  logic          cell_en;
  logic          cell_bit;
  logic          cell_start;

  assign cell_start = (ph == PW'(OSR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= '0;
      cell_en  <= 1'b0;
      cell_bit <= 1'b0;
    end else begin
      ph <= cell_start ? '0 : ph + 1'b1;
      if (cell_start) begin
        cell_en  <= tx_en;
        cell_bit <= tx_nrz;
      end
    end
  end

  assign tx_line = cell_level(cell_en, cell_bit, ph >= PW'(HALF));

  // R1: an enabled cell always toggles at its middle
  a_r1_mid_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && ph == PW'(HALF - 1)) |=> (tx_line != $past(tx_line)));

  // R2: a cell sampled with enable low stays low
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_start && !tx_en) |=> !tx_line);

endmodule

// File: rtl/manchester_rx_sync.sv
module manchester_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_lvl,
  output logic line_edge
);
  logic meta, sync, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      sync <= 1'b0;
      prev <= 1'b0;
    end else begin
      meta <= line_in;
      sync <= meta;
      prev <= sync;
    end
  end

  assign line_lvl  = sync;
  assign line_edge = sync ^ prev;

endmodule

// File: rtl/manchester_dec.sv
module manchester_dec #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_lvl,
  input  logic line_edge,
  output logic rx_clk,
  output logic rx_nrz,
  output logic rx_carrier
);
  import manchester_pkg::*;

  localparam int HALF = OSR / 2;
  localparam int WIN  = (3 * OSR) / 4;
  localparam int LOST = (3 * OSR) / 2;
  localparam int CW   = $clog2(LOST + 1);

  dec_state_t    st;
  logic [CW-1:0] cnt;
  logic          in_win, start_ev, acc_ev, lost_ev;

  assign in_win   = (cnt >= CW'(WIN));
  assign start_ev = line_edge && (st == S_IDLE);
  assign acc_ev   = line_edge && (st != S_IDLE) && in_win;
  assign lost_ev  = (st != S_IDLE) && !acc_ev && (cnt == CW'(LOST - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= CW'(LOST - 1);
      rx_nrz <= 1'b0;
    end else if (start_ev) begin
      st  <= S_CAND;
      cnt <= '0;
    end else if (acc_ev) begin
      st     <= S_LOCK;
      cnt    <= '0;
      rx_nrz <= line_lvl;
    end else if (lost_ev) begin
      st <= S_IDLE;
    end else if (st != S_IDLE) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign rx_carrier = (st == S_LOCK);
  assign rx_clk     = rx_carrier && (cnt < CW'(HALF));

  // R4: carrier rises only on an edge seen while holding a candidate
  a_r4_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_carrier) |-> ($past(line_edge) && $past(st == S_CAND)));

  // R5: edges inside the boundary zone leave the data untouched
  a_r5_ignore_early: assert property (@(posedge clk) disable iff (!rst_n)
    (line_edge && st != S_IDLE && cnt < CW'(WIN)) |=> $stable(rx_nrz));

  // R6: timeout with no edge drops carrier
  a_r6_timeout_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_carrier && cnt == CW'(LOST - 1) && !line_edge) |=> !rx_carrier);

  // R7: recovered clock is quiet once carrier is gone
  a_r7_clk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_carrier) |-> !rx_clk);

  // R3: each recovered clock pulse follows a line edge
  a_r3_clk_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_clk) |-> $past(line_edge));

endmodule

// File: rtl/manchester_endec.sv
module manchester_endec #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_nrz,
  output logic tx_line,
  input  logic rx_line,
  output logic rx_clk,
  output logic rx_nrz,
  output logic rx_carrier
);
  logic line_lvl, line_edge;

  manchester_enc #(.OSR(OSR)) u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .tx_nrz  (tx_nrz),
    .tx_line (tx_line)
  );

  manchester_rx_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (rx_line),
    .line_lvl  (line_lvl),
    .line_edge (line_edge)
  );

  manchester_dec #(.OSR(OSR)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_lvl   (line_lvl),
    .line_edge  (line_edge),
    .rx_clk     (rx_clk),
    .rx_nrz     (rx_nrz),
    .rx_carrier (rx_carrier)
  );

  // R9: outputs quiet right after reset release
  a_r9_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (!tx_line && !rx_clk && !rx_carrier));

endmodule

// File: tb/manchester_endec_bench.sv
module manchester_endec_bench;
  localparam int OSR  = 16;
  localparam int HALF = OSR / 2;
  localparam int JIT  = OSR / 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, tx_nrz = 1'b0, rx_line = 1'b0;
  logic tx_line, rx_clk, rx_nrz, rx_carrier;

  always #2.5 clk = ~clk;

  manchester_endec #(.OSR(OSR)) u_manchester_endec (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_nrz(tx_nrz),
    .tx_line(tx_line), .rx_line(rx_line), .rx_clk(rx_clk),
    .rx_nrz(rx_nrz), .rx_carrier(rx_carrier)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // expected line sample from R1/R2
  function automatic logic exp_line(input logic en, input logic b, input int ph);
    if (!en) return 1'b0;
    return (ph < HALF) ? ~b : b;
  endfunction

  // transmit reference: cell sampling per R2
  int   cyc = 0;
  logic m_en = 1'b0, m_bit = 1'b0;
  bit   enc_on = 1'b0;

  always @(posedge clk) begin
    if (rst_n) begin
      cyc <= cyc + 1;
      if (cyc % OSR == OSR - 1) begin
        m_en  <= tx_en;
        m_bit <= tx_nrz;
      end
    end
  end

  always @(negedge clk) begin
    if (enc_on) begin
      logic e;
      e = exp_line(m_en, m_bit, cyc % OSR);
      chk(tx_line === e, m_en ? "R1" : "R2", int'(tx_line), int'(e));
    end
  end

  // receive monitor
  logic cap [0:63];
  int   cap_n = 0;
  logic prev_rclk = 1'b0;
  bit   saw_car = 1'b0;

  always @(negedge clk) begin
    if (rx_clk && !prev_rclk && cap_n < 64) begin
      cap[cap_n] = rx_nrz;
      cap_n++;
    end
    prev_rclk = rx_clk;
    if (rx_carrier) saw_car = 1'b1;
  end

  task automatic send_rx(input int n, input logic [63:0] bits, input int jit);
    int   t [0:128];
    logic h [0:127];
    for (int k = 0; k < n; k++) begin
      h[2*k]   = ~bits[k];
      h[2*k+1] = bits[k];
    end
    for (int k = 0; k <= 2*n; k++) begin
      t[k] = k * HALF;
      if (k > 0 && k < 2*n && jit > 0)
        t[k] = t[k] + int'($urandom_range(2*jit, 0)) - jit;
    end
    for (int k = 0; k < 2*n; k++) begin
      rx_line = h[k];
      repeat (t[k+1] - t[k]) @(negedge clk);
    end
    rx_line = 1'b0;
  endtask

  task automatic rx_packet(input int n, input logic [63:0] bits, input int jit,
                           input string req);
    cap_n = 0;
    send_rx(n, bits, jit);
    chk(rx_carrier === 1'b1, "R4", int'(rx_carrier), 1);
    repeat (2*OSR) @(negedge clk);
    chk(rx_carrier === 1'b0, "R6", int'(rx_carrier), 0);
    chk(rx_clk === 1'b0, "R7", int'(rx_clk), 0);
    chk(cap_n == n - 1, req, cap_n, n - 1);
    for (int i = 1; i < n && i <= cap_n; i++)
      chk(cap[i-1] === bits[i], req, int'(cap[i-1]), int'(bits[i]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    logic [63:0] pk;
    int n;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(tx_line === 1'b0, "R9", int'(tx_line), 0);
    chk(rx_carrier === 1'b0, "R9", int'(rx_carrier), 0);
    chk(rx_clk === 1'b0, "R9", int'(rx_clk), 0);
    chk(rx_nrz === 1'b0, "R9", int'(rx_nrz), 0);
    rst_n = 1'b1;
    enc_on = 1'b1;

    // transmit: directed runs then random cells (R1, R2)
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      while (cyc % OSR != OSR - 1) @(negedge clk);
      if (c < 12)      begin tx_en = 1'b1; tx_nrz = 1'b1; end
      else if (c < 24) begin tx_en = 1'b1; tx_nrz = 1'b0; end
      else if (c < 36) begin tx_en = 1'b1; tx_nrz = logic'(c % 2); end
      else begin
        tx_en  = ($urandom_range(3, 0) != 0);
        tx_nrz = logic'($urandom_range(1, 0));
      end
    end
    @(negedge clk);
    while (cyc % OSR != OSR - 1) @(negedge clk);
    tx_en = 1'b0;
    repeat (2*OSR) @(negedge clk);
    enc_on = 1'b0;

    // R4: a lone edge longer than the timeout never raises carrier
    repeat (3*OSR) @(negedge clk);
    saw_car = 1'b0;
    rx_line = 1'b1;
    repeat (3*OSR) @(negedge clk);
    rx_line = 1'b0;
    repeat (3*OSR) @(negedge clk);
    chk(saw_car == 1'b0, "R4", int'(saw_car), 0);

    // R5: runs of equal bits put edges on every boundary
    rx_packet(32, 64'hFFFF_FFFF, 0, "R5");
    repeat (OSR) @(negedge clk);
    rx_packet(32, 64'h0000_0001, 0, "R5");
    repeat (OSR) @(negedge clk);

    // R3: clean random packets
    for (int p = 0; p < 8; p++) begin
      n  = int'($urandom_range(48, 8));
      pk = {$urandom, $urandom};
      pk[0] = 1'b1;
      rx_packet(n, pk, 0, "R3");
      repeat (int'($urandom_range(OSR, 0))) @(negedge clk);
    end

    // R8: jittered random packets
    for (int p = 0; p < 16; p++) begin
      n  = int'($urandom_range(60, 16));
      pk = {$urandom, $urandom};
      pk[0] = 1'b1;
      rx_packet(n, pk, JIT, "R8");
      repeat (int'($urandom_range(OSR, 0))) @(negedge clk);
    end

    finish_up();
  end

endmodule